// File: doc/BRIEF.md
# Operand Address Mode Resolver

This block turns the operand field of an 8-bit microcontroller instruction into one physical internal-memory access. The decode stage gives it an addressing mode, an operand byte, the 2-bit working-bank select and the current pointer registers R0 and R1 of the active bank. The block returns a target space (internal data RAM, special-function registers, or an immediate constant that needs no access), an 8-bit address and a one-cycle valid strobe.

Register operands are placed in the active bank. Direct addresses split at 0x80: the lower half goes to data RAM and the upper half to the SFR space. Indirect operands use R0 or R1 as the pointer and always go to data RAM across the full 0x00–0xFF range. As a result, the same byte 0x80–0xFF lands in SFR space or in upper RAM depending on the mode. The indirect path takes two cycles: the block first latches the selected pointer and then issues the RAM access. A busy output marks the extra cycle.

Top module: `opnd_resolver`

## Requirements
- R1: After a synchronous reset, `out_valid` and `busy` are 0, `out_space` is RAM (2'b00) and `out_addr` is 0x00.
- R2: Register mode (`mode`=2'b00): on the cycle after the request, the result is RAM space with address `bank`×8 + `spec[2:0]`. Bits `spec[7:3]` have no effect.
- R3: Direct mode (`mode`=2'b01) with `spec` below 0x80: on the cycle after the request, the result is RAM space with address `spec`.
- R4: Direct mode with `spec` at 0x80 or above: on the cycle after the request, the result is SFR space (2'b01) with address `spec`.
- R5: Indirect mode (`mode`=2'b10): `busy` is high for exactly the one cycle after the request, with `out_valid` low. On the cycle after that, the result is RAM space with the pointer value as address, for every pointer value 0x00–0xFF.
- R6: Immediate mode (`mode`=2'b11): on the cycle after the request, the result is immediate space (2'b10) and `out_addr` carries the constant `spec`.
- R7: A request presented while `busy` is high is ignored. It produces no extra `out_valid` pulse and does not change the pending indirect result.
- R8: `out_valid` is a single-cycle pulse. It is low in any cycle that follows a cycle with neither a request nor `busy`.
- R9: Indirect mode takes R0 (`r0_val`) when `spec[0]`=0 and R1 (`r1_val`) when `spec[0]`=1. The value is sampled in the request cycle, and later changes to `r0_val` or `r1_val` do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand resolution request |
| mode | input | 2 | Addressing mode: 00 register, 01 direct, 10 indirect, 11 immediate |
| spec | input | 8 | Register number (bits 2:0), direct address, pointer select (bit 0) or constant |
| bank | input | 2 | Active register bank |
| r0_val | input | 8 | Contents of R0 in the active bank |
| r1_val | input | 8 | Contents of R1 in the active bank |
| busy | output | 1 | High during the pointer-latch cycle of an indirect access |
| out_valid | output | 1 | Resolved access strobe |
| out_space | output | 2 | Target space: 00 RAM, 01 SFR, 10 immediate |
| out_addr | output | 8 | Resolved address or immediate constant |

## Verification
The assertions are checked on every cycle. They cover the busy timing of the indirect path, the mapping that the mode produces one cycle after each single-cycle request, the choice of R0 or R1 two cycles after an indirect request, and the rule that no strobe appears without a request. The bench's sweeps are needed for the rest. They cover every bank and register pair, both halves of the direct range at the 0x7F/0x80 boundary, every pointer value through both pointer registers, and every immediate constant. The scenarios also show that a request arriving during the busy cycle leaves no trace, and that pointer changes after the request cycle do not reach the result.

// File: rtl/opres_pkg.sv
package opres_pkg;
  localparam logic [1:0] MODE_REG = 2'b00;
  localparam logic [1:0] MODE_DIR = 2'b01;
  localparam logic [1:0] MODE_IND = 2'b10;
  localparam logic [1:0] MODE_IMM = 2'b11;

  localparam logic [1:0] SPC_RAM = 2'b00;
  localparam logic [1:0] SPC_SFR = 2'b01;
  localparam logic [1:0] SPC_IMM = 2'b10;
endpackage

// File: rtl/opres_decode.sv
module opres_decode
  import opres_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BANKW = 2,
  parameter int REGW  = 3
) (
  input  logic [1:0]       mode,
  input  logic [DW-1:0]    spec,
  input  logic [BANKW-1:0] bank,
  output logic [1:0]       space,
  output logic [DW-1:0]    addr
);
  localparam int RAW = BANKW + REGW;
  localparam int PADW = DW - RAW;

  logic [DW-1:0] reg_addr;

  generate
    if (PADW > 0) begin : g_pad
      assign reg_addr = {{PADW{1'b0}}, bank, spec[REGW-1:0]};
    end else begin : g_nopad
      assign reg_addr = {bank, spec[REGW-1:0]};
    end
  endgenerate

  always_comb begin
    space = SPC_RAM;
    addr  = spec;
    unique case (mode)
      MODE_REG: begin
        space = SPC_RAM;
        addr  = reg_addr;
      end
      MODE_DIR: begin
        space = spec[DW-1] ? SPC_SFR : SPC_RAM;
        addr  = spec;
      end
      MODE_IMM: begin
        space = SPC_IMM;
        addr  = spec;
      end
      default: begin
        space = SPC_RAM;
        addr  = spec;
      end
    endcase
  end
endmodule

// File: rtl/opres_ptr_sel.sv
module opres_ptr_sel #(
  parameter int DW = 8
) (
  input  logic          sel,
  input  logic [DW-1:0] r0_val,
  input  logic [DW-1:0] r1_val,
  output logic [DW-1:0] ptr
);
  assign ptr = sel ? r1_val : r0_val;
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opres_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BANKW = 2,
  parameter int REGW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       mode,
  input  logic [DW-1:0]    spec,
  input  logic [BANKW-1:0] bank,
  input  logic [DW-1:0]    r0_val,
  input  logic [DW-1:0]    r1_val,
  output logic             busy,
  output logic             out_valid,
  output logic [1:0]       out_space,
  output logic [DW-1:0]    out_addr
);
  logic [1:0]    dec_space;
  logic [DW-1:0] dec_addr;
  logic [DW-1:0] ptr_sel;
  logic [DW-1:0] ptr_q;
  logic          accept;

  opres_decode #(.DW(DW), .BANKW(BANKW), .REGW(REGW)) u_dec (
    .mode  (mode),
    .spec  (spec),
    .bank  (bank),
    .space (dec_space),
    .addr  (dec_addr)
  );

  opres_ptr_sel #(.DW(DW)) u_ptr (
    .sel    (spec[0]),
    .r0_val (r0_val),
    .r1_val (r1_val),
    .ptr    (ptr_sel)
  );

  assign accept = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_space <= SPC_RAM;
      out_addr  <= '0;
      ptr_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        busy      <= 1'b0;
        out_valid <= 1'b1;
        out_space <= SPC_RAM;
        out_addr  <= ptr_q;
      end else if (accept) begin
        if (mode == MODE_IND) begin
          busy  <= 1'b1;
          ptr_q <= ptr_sel;
        end else begin
          out_valid <= 1'b1;
          out_space <= dec_space;
          out_addr  <= dec_addr;
        end
      end
    end
  end
endmodule

// File: rtl/opres_chk.sv
module opres_chk #(
  parameter int DW    = 8,
  parameter int BANKW = 2,
  parameter int REGW  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       mode,
  input logic [DW-1:0]    spec,
  input logic [BANKW-1:0] bank,
  input logic [DW-1:0]    r0_val,
  input logic [DW-1:0]    r1_val,
  input logic             busy,
  input logic             out_valid,
  input logic [1:0]       out_space,
  input logic [DW-1:0]    out_addr
);
  logic take;
  assign take = req_valid && !busy;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R5
  AST_IND_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b10) |=> (busy && !out_valid)); // R5
  AST_BUSY_THEN_RAM: assert property (@(posedge clk) disable iff (rst)
    busy |=> (out_valid && out_space == 2'b00)); // R5
  AST_IND_R0: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b10 && !spec[0]) |=> ##1 (out_addr == $past(r0_val, 2))); // R9
  AST_IND_R1: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b10 && spec[0]) |=> ##1 (out_addr == $past(r1_val, 2))); // R9
  AST_REG_BANKED: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b00) |=>
      (out_valid && out_space == 2'b00 &&
       out_addr[REGW-1:0] == $past(spec[REGW-1:0]) &&
       out_addr[REGW+BANKW-1:REGW] == $past(bank))); // R2
  AST_DIR_LOW_RAM: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b01 && !spec[DW-1]) |=>
      (out_valid && out_space == 2'b00 && out_addr == $past(spec))); // R3
  AST_DIR_HIGH_SFR: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b01 && spec[DW-1]) |=>
      (out_valid && out_space == 2'b01 && out_addr == $past(spec))); // R4
  AST_IMM_PASS: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b11) |=>
      (out_valid && out_space == 2'b10 && out_addr == $past(spec))); // R6
  AST_NO_IDLE_VALID: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !busy) |=> !out_valid); // R8
  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && busy)); // R7
endmodule

bind opnd_resolver opres_chk #(.DW(DW), .BANKW(BANKW), .REGW(REGW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .mode      (mode),
  .spec      (spec),
  .bank      (bank),
  .r0_val    (r0_val),
  .r1_val    (r1_val),
  .busy      (busy),
  .out_valid (out_valid),
  .out_space (out_space),
  .out_addr  (out_addr)
);

// File: tb/tb_opnd_resolver.sv
module tb_opnd_resolver;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] mode;
  logic [7:0] spec;
  logic [1:0] bank;
  logic [7:0] r0_val;
  logic [7:0] r1_val;
  logic       busy;
  logic       out_valid;
  logic [1:0] out_space;
  logic [7:0] out_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_resolver dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .spec(spec),
    .bank(bank), .r0_val(r0_val), .r1_val(r1_val), .busy(busy),
    .out_valid(out_valid), .out_space(out_space), .out_addr(out_addr)
  );

  // packed view: {busy, valid, space, addr}
  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pk(input logic b, input logic v, input logic [1:0] s, input logic [7:0] a);
    return {b, v, s, a};
  endfunction

  // Single-cycle modes: drive at negedge, result visible after the next posedge.
  task automatic one_cycle(input string tag, input logic [1:0] m, input logic [7:0] sp,
                           input logic [1:0] bk, input logic [1:0] es, input logic [7:0] ea);
    @(negedge clk);
    req_valid = 1'b1; mode = m; spec = sp; bank = bk;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, pk(busy, out_valid, out_space, out_addr), pk(1'b0, 1'b1, es, ea));
  endtask

  // Indirect: busy cycle (with an intruding request and pointer change), then result.
  task automatic indirect(input string tag, input logic sel, input logic [7:0] p0,
                          input logic [7:0] p1, input logic [1:0] bk);
    logic [7:0] ea;
    ea = sel ? p1 : p0;
    @(negedge clk);
    req_valid = 1'b1; mode = 2'b10; spec = {7'h55, sel}; bank = bk;
    r0_val = p0; r1_val = p1;
    @(negedge clk);
    chk({tag, " R5 busy"}, {busy, out_valid, 10'h0}, {1'b1, 1'b0, 10'h0});
    // R7: a request during busy; R9: pointers change after sampling
    req_valid = 1'b1; mode = 2'b11; spec = ~ea;
    r0_val = ~p0; r1_val = ~p1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R5 R9 result"}, pk(busy, out_valid, out_space, out_addr),
        pk(1'b0, 1'b1, 2'b00, ea));
    @(negedge clk);
    chk({tag, " R7 ignored"}, pk(busy, out_valid, out_space, out_addr),
        pk(1'b0, 1'b0, 2'b00, ea));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; mode = 2'b00; spec = 8'h00; bank = 2'b00;
    r0_val = 8'h00; r1_val = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset", pk(busy, out_valid, out_space, out_addr), pk(1'b0, 1'b0, 2'b00, 8'h00));

    // R2: every bank and register, upper bits scrambled
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 8; r++) begin
        logic [7:0] sp;
        sp = (8'((b * 8 + r) * 37) & 8'hF8) | 8'(r);
        one_cycle("R2 register", 2'b00, sp, 2'(b), 2'b00, 8'(b * 8 + r));
      end
    end

    // R3/R4: whole direct range
    for (int a = 0; a < 256; a++) begin
      if (a < 128) one_cycle("R3 direct low", 2'b01, 8'(a), 2'(a), 2'b00, 8'(a));
      else         one_cycle("R4 direct high", 2'b01, 8'(a), 2'(a), 2'b01, 8'(a));
    end

    // R8: idle cycles give no strobe
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle", {busy, out_valid, 10'h0}, 12'h0);

    // R6: every constant
    for (int c = 0; c < 256; c++) begin
      one_cycle("R6 immediate", 2'b11, 8'(c), 2'(c >> 2), 2'b10, 8'(c));
    end
    @(negedge clk);
    chk("R8 pulse ends", {busy, out_valid, 10'h0}, 12'h0);

    // R5/R7/R9: every pointer value through both registers
    for (int p = 0; p < 256; p++) begin
      indirect("R9 via R0", 1'b0, 8'(p), 8'(255 - p), 2'(p));
      indirect("R9 via R1", 1'b1, 8'(p * 3), 8'(p), 2'(p >> 3));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule